// File: doc/BRIEF.md
# Parity-Synchronised Command Mailbox

This block is the device-side end of a small request/response channel between a host on a management bus and an embedded controller. The host uses three kinds of register: a command register, a read-only status register and a bank of eight 16-bit data registers. The data registers carry the request payload one way and the response payload the other way. Writing the command register posts a request. The mailbox then reports how that request is progressing through the status register.

Every command carries a parity bit, and the host flips it from one command to the next. The status register echoes the parity of the command it describes. The host treats a command as finished only when two things hold: the echoed parity equals the parity it sent, and the status code is no longer received (0x1), processing (0x2) or busy (0xE). The mailbox completes the no-op (opcode 0) on its own. It also uses no-ops to re-align parity after a loss of step. All other opcodes go to the controller over a request/response interface. The controller may also write the data registers directly.

Top module: `mbx_mailbox`

## Requirements
- R1: After reset the status register reads 0x000F (parity 0, size 0, opcode 0, code ready 0xF), the command register and all data registers read 0, and `ctl_req` is low.
- R2: Register offsets are: command at 0x1, status at 0x2, data register i at 0x8+i. Any other offset reads 0. A host write to the status offset has no effect on the value read back. The command offset reads back the last accepted command.
- R3: The host can write and read back each data register. The controller's data port also writes them. When both write the same register in the same cycle, the controller's value is kept.
- R4: A command write accepted while idle makes the status read, from the next cycle on and for exactly one cycle, {parity = command bit 15, size 0, opcode = command bits 5:0, code 0x1}. The status fields are parity bit 15, size bits 14:10, opcode bits 9:4 and code bits 3:0.
- R5: For a non-zero opcode the status then shows code 0x2 and `ctl_req` is high. While `ctl_req` is high, `ctl_opcode` presents command bits 5:0 and `ctl_size` presents command bits 10:6. This lasts until the controller responds.
- R6: A cycle in which `ctl_req` and `ctl_rsp_valid` are both high ends the command. On the next cycle the status holds the command's parity and opcode, the response size, and code 0x4 (or 0x8 when `ctl_rsp_err` is set), and `ctl_req` is low.
- R7: A response size above 16 bytes is reported as 16, with code 0x8.
- R8: A no-op goes from received directly to success 0x4 with size 0 and never raises `ctl_req`.
- R9: A no-op with parity 0 that follows an accepted no-op with parity 0 completes with code ready 0xF instead of success.
- R10: A command write that arrives while a command is received or processing sets the code to busy 0xE until completion, and the write is discarded. The command register, `ctl_opcode` and the final status all keep the command that was already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | ADDR_W | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_addr` (combinational) |
| ctl_req | output | 1 | A command is waiting for the controller |
| ctl_opcode | output | 6 | Opcode of the pending command |
| ctl_size | output | 5 | Payload byte count of the pending command |
| ctl_rsp_valid | input | 1 | Controller completes the pending command |
| ctl_rsp_err | input | 1 | Completion reports an error |
| ctl_rsp_size | input | RSP_W | Response byte count |
| ctl_dat_we | input | 1 | Controller data register write strobe |
| ctl_dat_idx | input | IDX_W | Controller data register index |
| ctl_dat_wdata | input | 16 | Controller data register write value |

## Verification
The status reads received one clock edge after the command write is sampled. One edge later it reads processing, or the final no-op result. The final result of a forwarded command appears one edge after the edge that samples the response. A busy code appears one edge after the colliding write, and a data register write is visible one edge after it is sampled. The bench drives inputs on falling edges and samples 5 ns after each rising edge. At that point it compares the read port and `ctl_req` against a behavioural model that it advances on the same edge. Directed checks with hand-computed literal values are taken at those same points.

// File: rtl/mbx_pkg.sv
// Shared encodings and the status word layout of the command mailbox.
package mbx_pkg;
    localparam logic [3:0] CODE_RCVD  = 4'h1;
    localparam logic [3:0] CODE_PROC  = 4'h2;
    localparam logic [3:0] CODE_OK    = 4'h4;
    localparam logic [3:0] CODE_ERR   = 4'h8;
    localparam logic [3:0] CODE_BUSY  = 4'hE;
    localparam logic [3:0] CODE_READY = 4'hF;

    // Status word as the host sees it, most significant field first.
    typedef struct packed {
        logic       par;
        logic [4:0] size;
        logic [5:0] opc;
        logic [3:0] code;
    } mbx_status_t;
endpackage

// File: rtl/mbx_datregs.sv
// Data register bank. The host and the controller can both write it, and the
// controller wins a same-cycle collision on one index.
// Assumes N fits the 5-bit byte-count fields (N <= 15).
module mbx_datregs #(
    parameter int N  = 8,
    parameter int W  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_we,
    input  logic [IW-1:0] h_idx,
    input  logic [W-1:0]  h_wdata,
    input  logic          c_we,
    input  logic [IW-1:0] c_idx,
    input  logic [W-1:0]  c_wdata,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        // One storage word; the controller write takes priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (c_we && c_idx == IW'(g))
                regs[g] <= c_wdata;
            else if (h_we && h_idx == IW'(g))
                regs[g] <= h_wdata;
        end
    end

    // Read port selection.
    assign rd_data = regs[rd_idx];

    // R3
    r3_ctl_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_we && h_we && c_idx == h_idx) |=> regs[$past(c_idx)] == $past(c_wdata));
endmodule

// File: rtl/mbx_handshake.sv
// Parity-tagged command sequencer. It accepts a command while idle, shows
// received for one cycle, then either finishes a no-op locally or waits in
// processing for the controller. Writes made while a command is in flight
// are dropped and flagged busy. Assumes MAXB < 32 and RSW >= 5.
module mbx_handshake
    import mbx_pkg::*;
#(
    parameter int MAXB = 16,
    parameter int RSW  = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_we,
    input  logic [15:0]    cmd_wdata,
    input  logic           rsp_valid,
    input  logic           rsp_err,
    input  logic [RSW-1:0] rsp_size,
    output mbx_status_t    status,
    output logic [15:0]    cmd_q,
    output logic           in_proc
);
    typedef enum logic [1:0] {PH_IDLE, PH_RCVD, PH_PROC} phase_e;

    phase_e     phase;
    logic       busy_q;
    logic       last_nop0;
    logic       resync_q;
    logic       is_nop0;
    logic       busy_n;
    logic       over;
    logic [4:0] rsz;

    // Classification of the incoming word and of the response.
    assign is_nop0 = !cmd_wdata[15] && (cmd_wdata[5:0] == 6'd0);
    assign busy_n  = busy_q | cmd_we;
    assign over    = rsp_size > RSW'(MAXB);
    assign rsz     = over ? 5'(MAXB) : rsp_size[4:0];
    assign in_proc = (phase == PH_PROC);

    // Phase sequence and the status word it publishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            status    <= '{par: 1'b0, size: 5'd0, opc: 6'd0, code: CODE_READY};
            cmd_q     <= '0;
            busy_q    <= 1'b0;
            last_nop0 <= 1'b0;
            resync_q  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (cmd_we) begin
                    phase     <= PH_RCVD;
                    cmd_q     <= cmd_wdata;
                    busy_q    <= 1'b0;
                    resync_q  <= last_nop0 && is_nop0;
                    last_nop0 <= is_nop0;
                    status    <= '{par: cmd_wdata[15], size: 5'd0,
                                   opc: cmd_wdata[5:0], code: CODE_RCVD};
                end
                PH_RCVD: begin
                    busy_q <= busy_n;
                    if (cmd_q[5:0] == 6'd0) begin
                        phase       <= PH_IDLE;
                        status.code <= resync_q ? CODE_READY : CODE_OK;
                    end else begin
                        phase       <= PH_PROC;
                        status.code <= busy_n ? CODE_BUSY : CODE_PROC;
                    end
                end
                PH_PROC: begin
                    if (rsp_valid) begin
                        phase       <= PH_IDLE;
                        busy_q      <= 1'b0;
                        status.size <= rsz;
                        status.code <= (over || rsp_err) ? CODE_ERR : CODE_OK;
                    end else if (cmd_we) begin
                        busy_q      <= 1'b1;
                        status.code <= CODE_BUSY;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R4
    r4_rcvd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status.code == CODE_RCVD) |=> (status.code != CODE_RCVD));
    // R4
    r4_parity_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && cmd_we) |=> (status.par == $past(cmd_wdata[15])));
    // R6
    r6_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_proc && rsp_valid) |=> (!in_proc && (status.code == CODE_OK || status.code == CODE_ERR)));
    // R7
    r7_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_proc && rsp_valid && over) |=> (status.size == 5'(MAXB) && status.code == CODE_ERR));
    // R8
    r8_nop_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RCVD && cmd_q[5:0] == 6'd0) |=> !in_proc);
    // R10
    r10_busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_proc && cmd_we && !rsp_valid) |=> (status.code == CODE_BUSY && $stable(cmd_q)));
endmodule

// File: rtl/mbx_mailbox.sv
// Command mailbox top. It decodes host offsets onto the command, status and
// data registers, and connects the sequencer to the controller interface.
// Assumes OFF_DATA + NREG fits within ADDR_W bits.
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int NREG     = 8,
    parameter int RSP_W    = 6,
    parameter int OFF_CMD  = 1,
    parameter int OFF_STS  = 2,
    parameter int OFF_DATA = 8,
    localparam int IDX_W   = $clog2(NREG),
    localparam int MAXB    = NREG * 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              ctl_req,
    output logic [5:0]        ctl_opcode,
    output logic [4:0]        ctl_size,
    input  logic              ctl_rsp_valid,
    input  logic              ctl_rsp_err,
    input  logic [RSP_W-1:0]  ctl_rsp_size,
    input  logic              ctl_dat_we,
    input  logic [IDX_W-1:0]  ctl_dat_idx,
    input  logic [15:0]       ctl_dat_wdata
);
    logic              hit_cmd;
    logic              hit_sts;
    logic              hit_dat;
    logic [ADDR_W-1:0] dat_off;
    logic [IDX_W-1:0]  dat_idx;
    logic [15:0]       dat_rd;
    logic [15:0]       cmd_q;
    mbx_status_t       status;

    // Offset decode.
    assign hit_cmd = host_addr == ADDR_W'(OFF_CMD);
    assign hit_sts = host_addr == ADDR_W'(OFF_STS);
    assign hit_dat = (host_addr >= ADDR_W'(OFF_DATA)) &&
                     ({1'b0, host_addr} < (ADDR_W + 1)'(OFF_DATA + NREG));
    assign dat_off = host_addr - ADDR_W'(OFF_DATA);
    assign dat_idx = dat_off[IDX_W-1:0];

    mbx_datregs #(.N(NREG), .W(16)) u_dat (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_we    (host_we && hit_dat),
        .h_idx   (dat_idx),
        .h_wdata (host_wdata),
        .c_we    (ctl_dat_we),
        .c_idx   (ctl_dat_idx),
        .c_wdata (ctl_dat_wdata),
        .rd_idx  (dat_idx),
        .rd_data (dat_rd)
    );

    mbx_handshake #(.MAXB(MAXB), .RSW(RSP_W)) u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (host_we && hit_cmd),
        .cmd_wdata (host_wdata),
        .rsp_valid (ctl_rsp_valid),
        .rsp_err   (ctl_rsp_err),
        .rsp_size  (ctl_rsp_size),
        .status    (status),
        .cmd_q     (cmd_q),
        .in_proc   (ctl_req)
    );

    // Controller view of the pending command.
    assign ctl_opcode = cmd_q[5:0];
    assign ctl_size   = cmd_q[10:6];

    // Host read multiplexer.
    always_comb begin
        if (hit_cmd)      host_rdata = cmd_q;
        else if (hit_sts) host_rdata = status;
        else if (hit_dat) host_rdata = dat_rd;
        else              host_rdata = 16'h0000;
    end

    // R2
    r2_sts_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && hit_sts && !ctl_req && status.code == CODE_READY) |=> $stable(status));
endmodule

// File: tb/mbx_mailbox_tb.sv
`timescale 1ns/1ps
module mbx_mailbox_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = 4'd2;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        ctl_req;
    logic [5:0]  ctl_opcode;
    logic [4:0]  ctl_size;
    logic        ctl_rsp_valid = 1'b0;
    logic        ctl_rsp_err = 1'b0;
    logic [5:0]  ctl_rsp_size = '0;
    logic        ctl_dat_we = 1'b0;
    logic [2:0]  ctl_dat_idx = '0;
    logic [15:0] ctl_dat_wdata = '0;

    int checks = 0;
    int errors = 0;
    bit started = 0;

    always #10 clk = ~clk;

    mbx_mailbox u_dut (.*);

    // Behavioural reference model state.
    int m_phase, m_sts, m_cmd, m_busy, m_prev, m_res;
    int m_dat[8];

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int exp_rd(int a);
        if (a == 1) return m_cmd;
        if (a == 2) return m_sts;
        if (a >= 8) return m_dat[a-8];
        return 0;
    endfunction

    // Advance the model on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_sts = 16'h000F; m_cmd = 0; m_busy = 0; m_prev = 0; m_res = 0;
            foreach (m_dat[i]) m_dat[i] = 0;
        end else begin
            automatic bit cw = host_we && host_addr == 4'd1;
            automatic int par = m_cmd & 16'h8000;
            automatic int opc = m_cmd & 63;
            if (host_we && host_addr >= 4'd8) m_dat[host_addr-8] = host_wdata;
            if (ctl_dat_we) m_dat[ctl_dat_idx] = ctl_dat_wdata;
            if (m_phase == 0) begin
                if (cw) begin
                    automatic bit n0 = (host_wdata & 16'h803F) == 0;
                    m_cmd = host_wdata; m_phase = 1; m_busy = 0;
                    m_res = m_prev && n0; m_prev = n0;
                    m_sts = (host_wdata & 16'h8000) | ((host_wdata & 63) << 4) | 1;
                end
            end else if (m_phase == 1) begin
                if (cw) m_busy = 1;
                if (opc == 0) begin
                    m_sts = par | (m_res ? 15 : 4); m_phase = 0;
                end else begin
                    m_sts = par | (opc << 4) | (m_busy ? 14 : 2); m_phase = 2;
                end
            end else begin
                if (ctl_rsp_valid) begin
                    automatic int sz = ctl_rsp_size;
                    automatic int cd = ctl_rsp_err ? 8 : 4;
                    if (sz > 16) begin sz = 16; cd = 8; end
                    m_sts = par | (sz << 10) | (opc << 4) | cd; m_phase = 0;
                end else if (cw) m_sts = par | (opc << 4) | 14;
            end
        end
    end

    // Compare against the model every cycle, 5 ns after the edge.
    always @(posedge clk) begin
        #5;
        if (started) begin
            chk("R4 R5 R6 model read", host_rdata, exp_rd(host_addr));
            chk("R5 model ctl_req", ctl_req, m_phase == 2);
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk); host_we = 1; host_addr = 4'(a); host_wdata = 16'(d);
        @(negedge clk); host_we = 0; host_addr = 4'd2;
    endtask

    task automatic peek(int a, int exp, string tag);
        host_addr = 4'(a); #1;
        chk(tag, host_rdata, exp);
        host_addr = 4'd2;
    endtask

    task automatic respond(bit err, int sz);
        @(negedge clk); ctl_rsp_valid = 1; ctl_rsp_err = err; ctl_rsp_size = 6'(sz);
        @(negedge clk); ctl_rsp_valid = 0; ctl_rsp_err = 0;
    endtask

    task automatic run_tests();
        repeat (3) @(negedge clk);
        rst_n = 1; started = 1;
        @(negedge clk);
        // R1 reset state
        peek(2, 16'h000F, "R1 status after reset");
        chk("R1 ctl_req after reset", ctl_req, 0);
        peek(1, 0, "R1 command reg after reset");
        peek(12, 0, "R1 data reg after reset");
        // R2 decode and read-only status
        peek(0, 0, "R2 unmapped offset 0");
        peek(5, 0, "R2 unmapped offset 5");
        wr(2, 16'h1234);
        peek(2, 16'h000F, "R2 status write ignored");
        // R3 data registers
        wr(11, 16'hBEEF);
        peek(11, 16'hBEEF, "R3 host write readback");
        @(negedge clk);
        host_we = 1; host_addr = 4'd13; host_wdata = 16'h2222;
        ctl_dat_we = 1; ctl_dat_idx = 3'd5; ctl_dat_wdata = 16'h1111;
        @(negedge clk);
        host_we = 0; ctl_dat_we = 0; host_addr = 4'd2;
        peek(13, 16'h1111, "R3 controller wins collision");
        // R4 R5 R6 forwarded command, parity 0, opcode 1, size 4
        wr(1, 16'h0101);
        peek(2, 16'h0011, "R4 received status");
        @(negedge clk);
        peek(2, 16'h0012, "R5 processing status");
        chk("R5 ctl_req high", ctl_req, 1);
        chk("R5 ctl_opcode", ctl_opcode, 1);
        chk("R5 ctl_size", ctl_size, 4);
        repeat (3) @(negedge clk);
        respond(0, 6);
        peek(2, 16'h1814, "R6 success status");
        chk("R6 ctl_req low", ctl_req, 0);
        peek(1, 16'h0101, "R2 command readback");
        // R6 error response with parity 1
        wr(1, 16'h8005);
        @(negedge clk);
        respond(1, 0);
        peek(2, 16'h8058, "R6 error status");
        // R7 oversize response
        wr(1, 16'h0002);
        @(negedge clk);
        respond(0, 20);
        peek(2, 16'h4028, "R7 clamped size");
        // R10 write during processing
        wr(1, 16'h8003);
        @(negedge clk);
        wr(1, 16'h0007);
        peek(2, 16'h803E, "R10 busy status");
        chk("R10 ctl_opcode kept", ctl_opcode, 3);
        peek(1, 16'h8003, "R10 command reg kept");
        respond(0, 2);
        peek(2, 16'h8834, "R10 final status of original");
        // R8 no-op handled locally
        wr(1, 16'h8000);
        peek(2, 16'h8001, "R8 no-op received");
        @(negedge clk);
        peek(2, 16'h8004, "R8 no-op success");
        chk("R8 no ctl_req", ctl_req, 0);
        // R9 resync pair
        wr(1, 16'h0000);
        @(negedge clk);
        peek(2, 16'h0004, "R9 first no-op success");
        wr(1, 16'h0000);
        @(negedge clk);
        peek(2, 16'h000F, "R9 second no-op ready");
        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            run_tests();
            begin
                #4_000_000;
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule